// File: doc/BRIEF.md
# Filtered Branch Trace Ring Buffer

This block keeps a short history of retired branches for performance analysis. Each retiring branch is first passed through a set of outcome and prediction filters. A branch that qualifies is stored as two adjacent entries in an eight-entry ring. The first entry holds the branch's own address together with its slot number within the bundle. The second entry holds the destination bundle address. The ring therefore keeps the four most recent qualifying branches. When it is full, the oldest pair is overwritten.

A write-position index and a sticky wrap flag sit beside the ring. They let software put the entries back into the order in which they were written. If the wrap flag is set, the oldest entry is the one at the index. If the flag is clear, the oldest entry is entry 0. Writing the index restarts capture: it moves the write position, clears the wrap flag and invalidates every entry. A one-cycle event pulse marks each stored pair, so an external counter can count captured branches. Entries are read out through a combinational select port.

Top module: `brtrace_ring`

## Requirements
- R1: After reset the index is 0, the wrap flag is 0, every entry reads with its valid bit at 0, and `branch_event` is 0.
- R2: A qualifying branch writes two entries in a single clock edge. The source entry goes at the index and reads {valid=1, b=1, mp, addr}, where addr is the branch bundle address with bits [3:0] replaced by the 2-bit slot number. The target entry goes at index+1 modulo 8 and reads {valid=1, b=0, mp, addr}, where addr is the destination address with bits [3:0] forced to 0. The `rd_data` layout is [ADDR_W+2]=valid, [ADDR_W+1]=b, [ADDR_W]=mp, [ADDR_W-1:0]=addr.
- R3: Each recorded branch advances the index by 2 modulo 8. The wrap flag sets when an advance passes entry 7 and stays set until the index is written. A filtered-out branch leaves the index unchanged.
- R4: `branch_event` is high for exactly the one cycle after each clock edge that records a pair, and is low otherwise.
- R5: The mp bit of a source entry is (target mispredicted OR path mispredicted). The mp bit of a target entry is (target mispredicted).
- R6: The taken filter `cfg_taken_sel` works as follows: 0 or 3 passes all branches, 1 passes taken branches only, 2 passes not-taken branches only.
- R7: The target-prediction filter `cfg_tgt_sel` works as follows: 0 or 3 passes all branches, 1 passes correctly predicted targets only, 2 passes mispredicted targets only.
- R8: The path-prediction filter `cfg_path_sel` uses the same encoding as R7, applied to the path misprediction input.
- R9: When `cfg_any_mp`=1, the target and path filters are ignored. A branch then qualifies if it passes the taken filter and has a target or a path misprediction.
- R10: With every configuration input at 0, every branch is recorded, whatever its outcome or prediction.
- R11: A pulse on `idx_wr` loads the index from `idx_wdata`, clears the wrap flag and clears every valid bit. A branch presented in the same cycle is not recorded and raises no event.
- R12: A fifth recorded branch overwrites the oldest pair. With the wrap flag set, walking the ring from the index in steps of 2 yields the source entries oldest first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| br_valid | input | 1 | A branch retires this cycle |
| br_bundle | input | ADDR_W | Address of the branch's bundle |
| br_slot | input | 2 | Slot of the branch within its bundle |
| br_dest | input | ADDR_W | Destination address of the branch |
| br_taken | input | 1 | The branch was taken |
| br_tgt_miss | input | 1 | The target prediction was wrong |
| br_path_miss | input | 1 | The path prediction was wrong |
| cfg_taken_sel | input | 2 | Taken filter select |
| cfg_tgt_sel | input | 2 | Target-prediction filter select |
| cfg_path_sel | input | 2 | Path-prediction filter select |
| cfg_any_mp | input | 1 | Record any mispredicted branch |
| idx_wr | input | 1 | Write strobe for the index |
| idx_wdata | input | IDX_W | New index value |
| rd_sel | input | IDX_W | Entry selected for readback |
| rd_data | output | ADDR_W+3 | Selected entry {valid, b, mp, addr} |
| idx_q | output | IDX_W | Next write position |
| wrap_q | output | 1 | Sticky wrap flag |
| branch_event | output | 1 | One pulse per recorded pair |

## Verification
The bench sweeps every combination of the filter selects and the all-mispredicted mode against all eight outcome/prediction combinations. A wrong filter decode would store a branch that should be dropped, or drop one that should be stored, and the sweep would see this as an unexpected index move or event. The bench also starts a branch from an odd index, so that the target entry lands at entry 0. A design that wrapped the second write incorrectly, or that missed the rollover when setting the wrap flag, would corrupt or fail to flag that entry. A fifth branch checks that overwriting lands on the oldest pair and that the chronological walk is correct. An index write in the same cycle as a branch checks that the write takes precedence.

// File: rtl/brtrace_ring.sv
module brtrace_ring #(
  parameter int ADDR_W     = 16,
  parameter int ENTRIES    = 8,
  parameter int BUNDLE_LSB = 4,
  parameter int SLOT_W     = 2,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int ENT_W     = ADDR_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_valid,
  input  logic [ADDR_W-1:0] br_bundle,
  input  logic [SLOT_W-1:0] br_slot,
  input  logic [ADDR_W-1:0] br_dest,
  input  logic              br_taken,
  input  logic              br_tgt_miss,
  input  logic              br_path_miss,
  input  logic [1:0]        cfg_taken_sel,
  input  logic [1:0]        cfg_tgt_sel,
  input  logic [1:0]        cfg_path_sel,
  input  logic              cfg_any_mp,
  input  logic              idx_wr,
  input  logic [IDX_W-1:0]  idx_wdata,
  input  logic [IDX_W-1:0]  rd_sel,
  output logic [ENT_W-1:0]  rd_data,
  output logic [IDX_W-1:0]  idx_q,
  output logic              wrap_q,
  output logic              branch_event
);

  logic [ADDR_W-1:0]  addr_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q, b_q, mp_q;

  function automatic logic sel_ok(input logic [1:0] sel, input logic miss);
    case (sel)
      2'd1:    return !miss;
      2'd2:    return miss;
      default: return 1'b1;
    endcase
  endfunction

  logic taken_ok, pred_ok, rec;
  assign taken_ok = (cfg_taken_sel == 2'd1) ? br_taken :
                    (cfg_taken_sel == 2'd2) ? !br_taken : 1'b1;
  assign pred_ok  = cfg_any_mp ? (br_tgt_miss || br_path_miss)
                               : (sel_ok(cfg_tgt_sel, br_tgt_miss) &&
                                  sel_ok(cfg_path_sel, br_path_miss));
  assign rec      = br_valid && !idx_wr && taken_ok && pred_ok;

  logic [IDX_W:0]     idx_sum;
  logic [IDX_W-1:0]   idx_nxt1;
  logic [ADDR_W-1:0]  src_addr, dst_addr;
  assign idx_sum  = {1'b0, idx_q} + (IDX_W+1)'(2);
  assign idx_nxt1 = idx_q + IDX_W'(1);
  assign src_addr = {br_bundle[ADDR_W-1:BUNDLE_LSB], (BUNDLE_LSB)'(br_slot)};
  assign dst_addr = {br_dest[ADDR_W-1:BUNDLE_LSB], {BUNDLE_LSB{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q        <= '0;
      wrap_q       <= 1'b0;
      branch_event <= 1'b0;
    end else begin
      branch_event <= rec;
      if (idx_wr) begin
        idx_q  <= idx_wdata;
        wrap_q <= 1'b0;
      end else if (rec) begin
        idx_q <= idx_sum[IDX_W-1:0];
        if (idx_sum[IDX_W]) wrap_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      b_q     <= '0;
      mp_q    <= '0;
      for (int i = 0; i < ENTRIES; i++) addr_q[i] <= '0;
    end else if (idx_wr) begin
      valid_q <= '0;
    end else if (rec) begin
      valid_q[idx_q]    <= 1'b1;
      b_q[idx_q]        <= 1'b1;
      mp_q[idx_q]       <= br_tgt_miss || br_path_miss;
      addr_q[idx_q]     <= src_addr;
      valid_q[idx_nxt1] <= 1'b1;
      b_q[idx_nxt1]     <= 1'b0;
      mp_q[idx_nxt1]    <= br_tgt_miss;
      addr_q[idx_nxt1]  <= dst_addr;
    end
  end

  assign rd_data = {valid_q[rd_sel], b_q[rd_sel], mp_q[rd_sel], addr_q[rd_sel]};

  // R3
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !rec && !idx_wr) |=> (idx_q == $past(idx_q)));

  // R3
  wrap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_q && !idx_wr) |=> wrap_q);

  // R11
  idx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> (!wrap_q && valid_q == '0 && !branch_event));

  // R4
  event_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_wr && !rec) |=> !branch_event);

  // R2
  pair_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec |=> (b_q[$past(idx_q)] && !b_q[$past(idx_nxt1)]));

endmodule

// File: tb/brtrace_ring_bench.sv
module brtrace_ring_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic clk = 0, rst_n = 0;
  logic br_valid = 0, br_taken = 0, br_tgt_miss = 0, br_path_miss = 0;
  logic [AW-1:0] br_bundle = '0, br_dest = '0;
  logic [1:0] br_slot = '0, cfg_taken_sel = '0, cfg_tgt_sel = '0, cfg_path_sel = '0;
  logic cfg_any_mp = 0, idx_wr = 0;
  logic [2:0] idx_wdata = '0, rd_sel = '0, idx_q;
  logic [AW+2:0] rd_data;
  logic wrap_q, branch_event;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brtrace_ring u_brtrace_ring (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_bundle(br_bundle),
    .br_slot(br_slot), .br_dest(br_dest), .br_taken(br_taken),
    .br_tgt_miss(br_tgt_miss), .br_path_miss(br_path_miss),
    .cfg_taken_sel(cfg_taken_sel), .cfg_tgt_sel(cfg_tgt_sel),
    .cfg_path_sel(cfg_path_sel), .cfg_any_mp(cfg_any_mp),
    .idx_wr(idx_wr), .idx_wdata(idx_wdata), .rd_sel(rd_sel),
    .rd_data(rd_data), .idx_q(idx_q), .wrap_q(wrap_q),
    .branch_event(branch_event));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_pass(input int ts, input int tsel, input int psel,
                                    input bit amp, input bit tk, input bit tm, input bit pm);
    bit a, b, c;
    a = (ts == 1) ? tk : (ts == 2) ? !tk : 1'b1;
    b = (tsel == 1) ? !tm : (tsel == 2) ? tm : 1'b1;
    c = (psel == 1) ? !pm : (psel == 2) ? pm : 1'b1;
    return amp ? (a && (tm || pm)) : (a && b && c);
  endfunction

  function automatic logic [AW+2:0] src_ent(input logic [AW-1:0] bnd, input int slot, input bit mp);
    return {1'b1, 1'b1, mp, bnd[AW-1:4], 4'(slot)};
  endfunction

  function automatic logic [AW+2:0] dst_ent(input logic [AW-1:0] d, input bit mp);
    return {1'b1, 1'b0, mp, d[AW-1:4], 4'h0};
  endfunction

  task automatic write_idx(input int v);
    @(negedge clk); idx_wr = 1; idx_wdata = 3'(v);
    @(negedge clk); idx_wr = 0;
  endtask

  task automatic send(input logic [AW-1:0] bnd, input int slot, input logic [AW-1:0] d,
                      input bit tk, input bit tm, input bit pm);
    @(negedge clk);
    br_valid = 1; br_bundle = bnd; br_slot = 2'(slot); br_dest = d;
    br_taken = tk; br_tgt_miss = tm; br_path_miss = pm;
    @(negedge clk); br_valid = 0;
  endtask

  function automatic logic [AW+2:0] peek_dummy(input int x); return '0; endfunction

  logic [AW-1:0] sb [5], db [5];

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 idx", idx_q, 0);
    check("R1 wrap", wrap_q, 0);
    check("R1 event", branch_event, 0);
    for (int e = 0; e < 8; e++) begin
      rd_sel = 3'(e); #1;
      check("R1 valid", rd_data[AW+2], 0);
    end

    // R6 R7 R8 R9 R10 filter sweep
    for (int ts = 0; ts < 4; ts++)
      for (int tsel = 0; tsel < 4; tsel++)
        for (int psel = 0; psel < 4; psel++)
          for (int amp = 0; amp < 2; amp++)
            for (int k = 0; k < 8; k++) begin
              bit tk, tm, pm, p;
              logic [AW-1:0] bnd, d;
              tk = k[0]; tm = k[1]; pm = k[2];
              p = exp_pass(ts, tsel, psel, amp[0], tk, tm, pm);
              write_idx(0);
              cfg_taken_sel = 2'(ts); cfg_tgt_sel = 2'(tsel);
              cfg_path_sel = 2'(psel); cfg_any_mp = amp[0];
              bnd = 16'h4000 + 16'(k * 16'h30);
              d   = 16'h8000 + 16'(ts * 16'h100) + 16'(k * 16'h10) + 16'h7;
              send(bnd, k % 3, d, tk, tm, pm);
              if (ts == 0 && tsel == 0 && psel == 0 && amp == 0) begin
                check("R10 default records", idx_q, 2);
              end else begin
                check("R6 R7 R8 R9 filter idx", idx_q, p ? 2 : 0);
              end
              check("R4 event", branch_event, p);
              if (p && k == 7) begin
                rd_sel = 0; #1;
                check("R2 R5 source", rd_data, src_ent(bnd, k % 3, tm | pm));
                rd_sel = 1; #1;
                check("R2 R5 target", rd_data, dst_ent(d, tm));
              end
              if (p && k == 2) begin
                rd_sel = 0; #1;
                check("R5 source mp", rd_data[AW], 1);
                rd_sel = 1; #1;
                check("R5 target mp", rd_data[AW], 1);
              end
              if (p && k == 4) begin
                rd_sel = 1; #1;
                check("R5 target mp path only", rd_data[AW], 0);
              end
              @(negedge clk);
              check("R4 single pulse", branch_event, 0);
            end
    cfg_taken_sel = 0; cfg_tgt_sel = 0; cfg_path_sel = 0; cfg_any_mp = 0;

    // R3 R12 ring fill and overwrite
    write_idx(0);
    for (int n = 0; n < 5; n++) begin
      sb[n] = 16'h1000 + 16'(n * 16'h100);
      db[n] = 16'h2000 + 16'(n * 16'h40);
      send(sb[n], n % 3, db[n], 1, 0, 0);
      check("R3 idx advance", idx_q, ((n + 1) * 2) % 8);
      check("R3 wrap", wrap_q, (n >= 3) ? 1 : 0);
    end
    rd_sel = 0; #1;
    check("R12 overwrite source", rd_data, src_ent(sb[4], 1, 0));
    rd_sel = 1; #1;
    check("R12 overwrite target", rd_data, dst_ent(db[4], 0));
    for (int j = 0; j < 4; j++) begin
      rd_sel = 3'((idx_q + 2 * j) % 8); #1;
      check("R12 chrono order", rd_data, src_ent(sb[1 + j], (1 + j) % 3, 0));
    end

    // R11 odd index split pair, and clear
    write_idx(7);
    check("R11 idx load", idx_q, 7);
    check("R11 wrap clear", wrap_q, 0);
    for (int e = 0; e < 8; e++) begin
      rd_sel = 3'(e); #1;
      check("R11 valid clear", rd_data[AW+2], 0);
    end
    send(16'h3330, 2, 16'h5550, 0, 1, 0);
    check("R3 odd wrap idx", idx_q, 1);
    check("R3 odd wrap flag", wrap_q, 1);
    rd_sel = 7; #1;
    check("R2 source at 7", rd_data, src_ent(16'h3330, 2, 1));
    rd_sel = 0; #1;
    check("R2 target at 0", rd_data, dst_ent(16'h5550, 1));

    // R11 index write wins over same-cycle branch
    @(negedge clk);
    idx_wr = 1; idx_wdata = 3; br_valid = 1; br_taken = 1;
    @(negedge clk);
    idx_wr = 0; br_valid = 0;
    check("R11 idx priority", idx_q, 3);
    check("R11 no event", branch_event, 0);
    rd_sel = 3; #1;
    check("R11 no record", rd_data[AW+2], 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule